// File: doc/BRIEF.md
# Signed Residue Scaler via Mixed-Radix Digits

This block divides a signed number held in residue form by a fixed constant and returns the quotient, again in residue form, together with a sign flag. The base has four pairwise coprime moduli, by default 7, 11, 13 and 15, so the range is M = 15015. The divisor is the product of the first `SCALE_CNT` moduli in the conversion order. With the defaults this is 7·11 = 77. A caller presents one residue word per cycle with a valid strobe. Exactly four cycles later it receives the scaled residues and the sign.

Inside, three pipelined digit stages turn the residues into mixed-radix digits a0..a3, where X = a0 + a1·m0 + a2·m0·m1 + a3·m0·m1·m2. Each stage is a modulo subtractor followed by a multiply by a constant modular inverse. The digits below the divisor are dropped, which gives the floor quotient, so the scaling error is less than one. The higher digits are weighted and reduced per output modulus, then summed in binary. A number is negative when its top digit reaches half of the top modulus. In that case the constant M/S is subtracted before the final reduction, so a negative value X is scaled as X − M.

Top module: `rns_signed_scaler`

## Requirements
- R1: A sample taken while `inValid` is high at a rising edge produces `outValid` high for exactly one cycle after the fourth following rising edge. `outValid` is low in every other cycle.
- R2: `outNeg` is 1 exactly when the top mixed-radix digit is at least 8. With the defaults this means the number X (0..15014) whose residues were given is 8008 or more.
- R3: For a positive input, `outRes` holds the residues of floor(X/77).
- R4: For a negative input, `outRes` holds the non-negative residues of floor(X/77) − 195, which equals (X − 15015)/77 rounded toward minus infinity.
- R5: The fields are packed as follows: bits [4i+3:4i] of `inRes` and of `outRes` hold the residue modulo MODi, i = 0..3, with defaults 7, 11, 13 and 15.
- R6: In a cycle without a result, `outRes` and `outNeg` keep their last values and `outValid` stays low.
- R7: After reset, `outValid`, `outRes` and `outNeg` are all zero.
- R8: A new sample can be accepted on every cycle, and each one is scaled independently of its neighbours.
- R9: The boundary cases are fixed. X=0 gives 0 and positive. X=8007 gives 103 and positive, with residues (5,4,12,13). X=8008 gives −91 and negative, with residues (0,8,0,14). X=15014 gives −1 and negative, with residues (6,10,12,14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample strobe |
| inRes | input | 16 | Input residues, 4 bits per modulus |
| outValid | output | 1 | Result strobe |
| outRes | output | 16 | Scaled residues, 4 bits per modulus |
| outNeg | output | 1 | Sign of the input, 1 = negative |

## Verification
Two things can happen in the same cycle: a new sample enters the digit stages while an older result leaves the output register. The sign can also flip between results that follow each other directly. The sweep feeds every value of the range back to back, with idle gaps scattered through it. A second pass alternates small and large values so that the sign toggles every cycle. Each output cycle is compared with the value computed arithmetically for the sample issued four cycles earlier. An idle slot must show the last result unchanged.

// File: rtl/rns_scale_pkg.sv
package rns_scale_pkg;
  localparam int NUM_MODS = 4;
  localparam int RES_W = 4;

  typedef logic [NUM_MODS-1:0][RES_W-1:0] res_vec_t;

  typedef struct packed {
    logic [NUM_MODS-2:0] stageEn;
    logic outEn;
  } scale_strobe_t;

  // Multiplicative inverse of a modulo m, found by search at elaboration.
  function automatic int mod_inv(int a, int m);
    for (int k = 1; k < m; k++) begin
      if (((a * k) % m) == 1) return k;
    end
    return 0;
  endfunction

  // Product of moduli with index lo..hi-1, reduced modulo m.
  function automatic int span_mod(int m0, int m1, int m2, int m3, int lo, int hi, int m);
    int arr [NUM_MODS];
    int v;
    arr[0] = m0; arr[1] = m1; arr[2] = m2; arr[3] = m3;
    v = 1 % m;
    for (int l = lo; l < hi; l++) v = (v * arr[l]) % m;
    return v;
  endfunction
endpackage

// File: rtl/mod_mac_lane.sv
// Modified two-operand modulo adder: y = ((a - b) * COEF) mod MOD.
module mod_mac_lane
  import rns_scale_pkg::*;
#(
  parameter int MOD = 11,
  parameter int COEF = 1
) (
  input  logic [RES_W-1:0] a,
  input  logic [RES_W-1:0] b,
  output logic [RES_W-1:0] y
);
  localparam int AW = 2 * RES_W + 1;

  logic [AW-1:0] bRed;
  logic [AW-1:0] diffSum;
  logic [AW-1:0] diffRed;
  logic [AW-1:0] prod;
  logic [AW-1:0] prodRed;

  assign bRed    = AW'(b) % AW'(MOD);
  assign diffSum = AW'(a) + AW'(MOD) - bRed;
  assign diffRed = diffSum % AW'(MOD);
  assign prod    = diffRed * AW'(COEF);
  assign prodRed = prod % AW'(MOD);
  assign y       = prodRed[RES_W-1:0];
endmodule

// File: rtl/mrs_digit_stage.sv
// One mixed-radix conversion step: fixes digit STEP, updates higher lanes.
module mrs_digit_stage
  import rns_scale_pkg::*;
#(
  parameter int STEP = 0,
  parameter int MOD0 = 7,
  parameter int MOD1 = 11,
  parameter int MOD2 = 13,
  parameter int MOD3 = 15
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     en,
  input  res_vec_t xIn,
  output res_vec_t xOut
);
  localparam int MODS [NUM_MODS] = '{MOD0, MOD1, MOD2, MOD3};

  res_vec_t nxt;

  for (genvar j = 0; j < NUM_MODS; j++) begin : g_lane
    if (j <= STEP) begin : g_pass
      assign nxt[j] = xIn[j];
    end else begin : g_step
      mod_mac_lane #(
        .MOD (MODS[j]),
        .COEF(mod_inv(MODS[STEP] % MODS[j], MODS[j]))
      ) u_lane (
        .a(xIn[j]),
        .b(xIn[STEP]),
        .y(nxt[j])
      );
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xOut <= '0;
    else if (en) xOut <= nxt;
  end
endmodule

// File: rtl/rns_scale_ctrl.sv
module rns_scale_ctrl
  import rns_scale_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output scale_strobe_t stb,
  output logic          outValid
);
  logic [NUM_MODS-1:0] vld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vld <= '0;
    else vld <= {vld[NUM_MODS-2:0], inValid};
  end

  assign stb.stageEn = {vld[NUM_MODS-3:0], inValid};
  assign stb.outEn   = vld[NUM_MODS-2];
  assign outValid    = vld[NUM_MODS-1];
endmodule

// File: rtl/rns_scale_dp.sv
module rns_scale_dp
  import rns_scale_pkg::*;
#(
  parameter int MOD0 = 7,
  parameter int MOD1 = 11,
  parameter int MOD2 = 13,
  parameter int MOD3 = 15,
  parameter int SCALE_CNT = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  scale_strobe_t stb,
  input  res_vec_t      inRes,
  output res_vec_t      outRes,
  output logic          outNeg
);
  localparam int MODS [NUM_MODS] = '{MOD0, MOD1, MOD2, MOD3};
  localparam int AW = 2 * RES_W + 1;
  localparam int TOP_THR = (MODS[NUM_MODS-1] + 1) / 2;

  res_vec_t stageQ [NUM_MODS-1];
  res_vec_t digits;
  res_vec_t resNext;
  logic     negNow;

  for (genvar k = 0; k < NUM_MODS - 1; k++) begin : g_stage
    mrs_digit_stage #(
      .STEP(k), .MOD0(MOD0), .MOD1(MOD1), .MOD2(MOD2), .MOD3(MOD3)
    ) u_stage (
      .clk (clk),
      .rstN(rstN),
      .en  (stb.stageEn[k]),
      .xIn ((k == 0) ? inRes : stageQ[(k == 0) ? 0 : k-1]),
      .xOut(stageQ[k])
    );
  end

  assign digits = stageQ[NUM_MODS-2];
  assign negNow = (int'(digits[NUM_MODS-1]) >= TOP_THR);

  for (genvar j = 0; j < NUM_MODS; j++) begin : g_out
    localparam int MJ = MODS[j];
    localparam int OFFJ = (MJ - span_mod(MOD0, MOD1, MOD2, MOD3, SCALE_CNT, NUM_MODS, MJ)) % MJ;
    logic [NUM_MODS-1:0][AW-1:0] term;
    logic [AW-1:0] acc;
    logic [AW-1:0] accRed;

    for (genvar i = 0; i < NUM_MODS; i++) begin : g_term
      if (i >= SCALE_CNT) begin : g_keep
        localparam int CIJ = span_mod(MOD0, MOD1, MOD2, MOD3, SCALE_CNT, i, MJ);
        assign term[i] = (AW'(digits[i]) * AW'(CIJ)) % AW'(MJ);
      end else begin : g_drop
        assign term[i] = '0;
      end
    end

    always_comb begin
      acc = negNow ? AW'(OFFJ) : '0;
      for (int i = 0; i < NUM_MODS; i++) acc = acc + term[i];
    end

    assign accRed = acc % AW'(MJ);
    assign resNext[j] = accRed[RES_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outRes <= '0;
      outNeg <= 1'b0;
    end else if (stb.outEn) begin
      outRes <= resNext;
      outNeg <= negNow;
    end
  end

  // R2: every finished mixed-radix digit lies below its own modulus.
  for (genvar k = 0; k < NUM_MODS; k++) begin : g_chk
    p_digit_range_r2 : assert property (@(posedge clk) disable iff (!rstN)
      stb.outEn |-> (int'(digits[k]) < MODS[k]));
  end

  // R6: the output register keeps its value when no result is loaded.
  p_hold_r6 : assert property (@(posedge clk) disable iff (!rstN)
    !stb.outEn |=> ($stable(outRes) && $stable(outNeg)));
endmodule

// File: rtl/rns_signed_scaler.sv
module rns_signed_scaler
  import rns_scale_pkg::*;
#(
  parameter int MOD0 = 7,
  parameter int MOD1 = 11,
  parameter int MOD2 = 13,
  parameter int MOD3 = 15,
  parameter int SCALE_CNT = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [NUM_MODS*RES_W-1:0] inRes,
  output logic                      outValid,
  output logic [NUM_MODS*RES_W-1:0] outRes,
  output logic                      outNeg
);
  scale_strobe_t stb;
  res_vec_t      resQ;

  rns_scale_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .stb     (stb),
    .outValid(outValid)
  );

  rns_scale_dp #(
    .MOD0(MOD0), .MOD1(MOD1), .MOD2(MOD2), .MOD3(MOD3), .SCALE_CNT(SCALE_CNT)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .inRes (res_vec_t'(inRes)),
    .outRes(resQ),
    .outNeg(outNeg)
  );

  assign outRes = resQ;

  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd4) sinceRst <= sinceRst + 3'd1;
  end

  // R1: result strobe trails the input strobe by four edges.
  p_latency_r1 : assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 3'd4) |-> (outValid == $past(inValid, 4)));

  // R3: zero scales to a positive zero.
  p_zero_r3 : assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst == 3'd4) && $past(inValid, 4) && ($past(inRes, 4) == '0))
      |-> ((outRes == '0) && !outNeg));
endmodule

// File: tb/rns_signed_scaler_test.sv
`timescale 1ns/1ps
module rns_signed_scaler_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inRes = '0;
  logic        outValid;
  logic [15:0] outRes;
  logic        outNeg;

  int nTests = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 0;

  bit          expV [8];
  logic [15:0] expR [8];
  bit          expN [8];
  int          expX [8];
  logic [15:0] lastR = '0;
  bit          lastN = 0;

  rns_signed_scaler uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRes(inRes),
    .outValid(outValid), .outRes(outRes), .outNeg(outNeg)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] packR(int r0, int r1, int r2, int r3);
    return {4'(r3), 4'(r2), 4'(r1), 4'(r0)};
  endfunction

  function automatic logic [15:0] toRes(int v);
    return packR(((v % 7) + 7) % 7, ((v % 11) + 11) % 11,
                 ((v % 13) + 13) % 13, ((v % 15) + 15) % 15);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  task automatic step(bit v, int x);
    int slot;
    int ns;
    int y;
    @(negedge clk);
    slot = cyc % 8;
    if (expV[slot]) begin
      check(outValid == 1'b1, "R1/R8 valid", int'(outValid), 1);
      check(outNeg == expN[slot], "R2 sign", int'(outNeg), int'(expN[slot]));
      if (expN[slot]) check(outRes == expR[slot], "R4 negative result", int'(outRes), int'(expR[slot]));
      else check(outRes == expR[slot], "R3 positive result", int'(outRes), int'(expR[slot]));
      case (expX[slot])
        0:     check(outRes == packR(0, 0, 0, 0) && !outNeg, "R9 X=0", int'(outRes), 0);
        8007:  check(outRes == packR(5, 4, 12, 13) && !outNeg, "R9 X=8007", int'(outRes), int'(packR(5, 4, 12, 13)));
        8008:  check(outRes == packR(0, 8, 0, 14) && outNeg, "R9 X=8008", int'(outRes), int'(packR(0, 8, 0, 14)));
        15014: check(outRes == packR(6, 10, 12, 14) && outNeg, "R9 X=15014", int'(outRes), int'(packR(6, 10, 12, 14)));
        default: ;
      endcase
      lastR = outRes;
      lastN = outNeg;
      expV[slot] = 0;
    end else begin
      check(outValid == 1'b0, "R6 idle strobe", int'(outValid), 0);
      check(outRes == lastR && outNeg == lastN, "R6 hold", int'(outRes), int'(lastR));
    end
    inValid = v;
    inRes = toRes(x);
    if (v) begin
      ns = (cyc + 4) % 8;
      expV[ns] = 1;
      expX[ns] = x;
      expN[ns] = (x >= 8008);
      y = x / 77 - ((x >= 8008) ? 195 : 0);
      expR[ns] = toRes(y);
    end
    cyc++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) expV[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7: reset state
    check(outValid == 1'b0, "R7 reset valid", int'(outValid), 0);
    check(outRes == '0, "R7 reset residues", int'(outRes), 0);
    check(outNeg == 1'b0, "R7 reset sign", int'(outNeg), 0);

    // R5/R8: full-range sweep, back to back with scattered gaps
    for (int x = 0; x < 15015; x++) begin
      if ((x % 53) == 17) step(0, 0);
      step(1, x);
    end
    // sign toggles every cycle
    for (int k = 0; k < 300; k++) begin
      step(1, k * 7);
      step(1, 15014 - k * 5);
    end
    for (int k = 0; k < 8; k++) step(0, 0);
    done = 1;
    summary();
  end
endmodule